// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block watches one direction of Ethernet frame traffic and keeps a bank of statistics counters that software reads through a simple word-addressed read port. Upstream logic hands over one summary per frame, at the end of the frame: the frame length in bytes, an FCS error flag, an address class (unicast, multicast or broadcast), a control-frame flag, a pause-frame flag, and jabber and fragment indications. In the same clock the block sorts the frame into a size bin, into an errored or OK counter for its class, into the error-cause counters that apply, and adds its octets to two wide running totals.

Software reads a counter by placing a word address on the read port. A bank responds only to addresses whose upper byte matches its base parameter, so one instance at base 0x0800 serves transmit traffic and a second at 0x0900 serves receive traffic. The two octet totals are wider than a read word. They are read low word first, and that read latches the upper word, so the pair always forms one consistent value. A single clear pulse zeroes the whole bank. Counters stop at their maximum value instead of wrapping.

Top module: `frame_stats_bank`

## Requirements
- R1: Every reported frame is counted in one length bin by its byte length: offset 11 for exactly 64, 12 for 65..127, 13 for 128..255, 14 for 256..511, 15 for 512..1023, 16 for 1024..1518, 17 for 1519..MAX_LEN, 18 above MAX_LEN. A frame shorter than 64 bytes counts in no bin.
- R2: Offset 0 counts frames with the fragment flag, offset 1 frames with the jabber flag, and offset 2 frames with the FCS error flag. Offset 3 counts FCS-errored frames only when the length is 64..MAX_LEN and neither the fragment nor the jabber flag is set.
- R3: A frame is errored when its FCS error, jabber or fragment flag is set. An errored frame without the pause flag counts at offset 4 + 3*ctrl + class, where the class field is 0 for unicast, 1 for multicast and 2 for broadcast (class 3 counts in no class counter). An errored pause frame counts at offset 10 only.
- R4: A frame that is not errored counts at offset 20 + 3*ctrl + class with the same class encoding; a pause frame that is not errored counts at offset 26 only.
- R5: Offset 19 counts every reported frame, errored or not.
- R6: For each frame that is not errored, the payload total grows by length minus 18 (floored at zero) and the frame total grows by the length; errored frames add nothing.
- R7: Every counter and total stops at its all-ones value rather than wrapping to zero.
- R8: A clear pulse sets all counters and both totals to zero on the next edge, and wins over a frame reported in the same cycle.
- R9: A read of a word address whose upper byte matches the bank base returns, one cycle later, the counter at the offset given by the low byte (zero-extended), the payload total low and high words at offsets 0x20 and 0x21, and the frame total low and high words at 0x22 and 0x23. Any other offset, or an address outside the bank, returns zero. The read data holds its value while no read is requested.
- R10: Reading the low word of a total latches that total's upper word, and a later read of the high word returns the latched value even if the total has since changed.
- R11: Summary inputs presented without the frame-valid strobe change no counter and no total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fr_valid | input | 1 | One-cycle strobe: a frame summary is present |
| fr_len | input | LEN_W | Frame length in bytes |
| fr_fcs_err | input | 1 | Frame had an FCS error |
| fr_cls | input | 2 | Address class: 0 unicast, 1 multicast, 2 broadcast, 3 none |
| fr_ctrl | input | 1 | Frame is a control frame |
| fr_pause | input | 1 | Frame is a pause frame |
| fr_jabber | input | 1 | Frame was a jabber |
| fr_fragment | input | 1 | Frame was a fragment |
| clr_all | input | 1 | Clear all counters and totals |
| rd_en | input | 1 | Read request |
| rd_addr | input | 16 | Word address of the read |
| rd_data | output | DATA_W | Read data, valid the cycle after the request |

## Verification
The hardest situation to reach from the ports is the split read of a total whose upper word changes between the two halves, since that needs the total to cross a word boundary between two reads. The bench narrows the read word to 16 bits and the counters to 8 bits by parameter, reads a payload low word, then sends eight maximum-length good frames so the total carries past the boundary before the high word is read. The narrow counters also let a few hundred minimum-size frames drive three counters into saturation, and a clear is issued in the same cycle as a frame to show which one wins.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  // counter offsets within a bank
  localparam int IX_FRAG      = 0;
  localparam int IX_JAB       = 1;
  localparam int IX_FCS_ANY   = 2;
  localparam int IX_FCS_SIZED = 3;
  localparam int IX_ERR_CLS   = 4;   // 4..9 : 3*ctrl + class
  localparam int IX_ERR_PAUSE = 10;
  localparam int IX_BIN       = 11;  // 11..18
  localparam int NUM_BINS     = 8;
  localparam int IX_STARTS    = 19;
  localparam int IX_OK_CLS    = 20;  // 20..25
  localparam int IX_OK_PAUSE  = 26;
  localparam int NUM_CNT      = 27;

  // offsets of the wide totals
  localparam logic [7:0] OFF_PAY_LO = 8'h20;
  localparam logic [7:0] OFF_PAY_HI = 8'h21;
  localparam logic [7:0] OFF_FRM_LO = 8'h22;
  localparam logic [7:0] OFF_FRM_HI = 8'h23;

  localparam int HDR_FCS_BYTES = 18;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_NONE  = 2'd3
  } addr_cls_e;
endpackage

// File: rtl/fstat_classify.sv
module fstat_classify
  import fstat_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 9600
) (
  input  logic                fr_valid,
  input  logic [LEN_W-1:0]    fr_len,
  input  logic                fr_fcs_err,
  input  logic [1:0]          fr_cls,
  input  logic                fr_ctrl,
  input  logic                fr_pause,
  input  logic                fr_jabber,
  input  logic                fr_fragment,
  output logic [NUM_CNT-1:0]  inc,
  output logic [LEN_W-1:0]    pay_add,
  output logic [LEN_W-1:0]    frm_add
);
  localparam logic [LEN_W-1:0] L64  = LEN_W'(64);
  localparam logic [LEN_W-1:0] LMAX = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LHDR = LEN_W'(HDR_FCS_BYTES);

  logic errored;
  logic sized;
  logic [NUM_BINS-1:0] bin_hit;

  assign errored = fr_fcs_err | fr_jabber | fr_fragment;
  assign sized   = (fr_len >= L64) && (fr_len <= LMAX);

  // length bins, one-hot or empty
  always_comb begin
    bin_hit = '0;
    if (fr_len == L64)                                bin_hit[0] = 1'b1;
    else if (fr_len > L64  && fr_len <= LEN_W'(127))  bin_hit[1] = 1'b1;
    else if (fr_len >= LEN_W'(128)  && fr_len <= LEN_W'(255))  bin_hit[2] = 1'b1;
    else if (fr_len >= LEN_W'(256)  && fr_len <= LEN_W'(511))  bin_hit[3] = 1'b1;
    else if (fr_len >= LEN_W'(512)  && fr_len <= LEN_W'(1023)) bin_hit[4] = 1'b1;
    else if (fr_len >= LEN_W'(1024) && fr_len <= LEN_W'(1518)) bin_hit[5] = 1'b1;
    else if (fr_len >= LEN_W'(1519) && fr_len <= LMAX)         bin_hit[6] = 1'b1;
    else if (fr_len > LMAX)                                    bin_hit[7] = 1'b1;
  end

  always_comb begin
    inc = '0;
    if (fr_valid) begin
      inc[IX_FRAG]      = fr_fragment;
      inc[IX_JAB]       = fr_jabber;
      inc[IX_FCS_ANY]   = fr_fcs_err;
      inc[IX_FCS_SIZED] = fr_fcs_err & sized & ~fr_fragment & ~fr_jabber;
      inc[IX_STARTS]    = 1'b1;
      for (int b = 0; b < NUM_BINS; b++) inc[IX_BIN + b] = bin_hit[b];
      if (fr_pause) begin
        if (errored) inc[IX_ERR_PAUSE] = 1'b1;
        else         inc[IX_OK_PAUSE]  = 1'b1;
      end else begin
        for (int c = 0; c < 3; c++) begin
          if (fr_cls == 2'(c)) begin
            if (errored) inc[IX_ERR_CLS + (fr_ctrl ? 3 : 0) + c] = 1'b1;
            else         inc[IX_OK_CLS  + (fr_ctrl ? 3 : 0) + c] = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    pay_add = '0;
    frm_add = '0;
    if (fr_valid && !errored) begin
      frm_add = fr_len;
      pay_add = (fr_len >= LHDR) ? (fr_len - LHDR) : '0;
    end
  end
endmodule

// File: rtl/fstat_acc.sv
module fstat_acc #(
  parameter int W  = 32,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [IW-1:0] add,
  output logic [W-1:0]  q
);
  logic [W:0]   sum;
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    sum   = {1'b0, q} + (W+1)'(add);
    q_en  = clr | (add != '0);
    if (clr)         q_nxt = '0;
    else if (sum[W]) q_nxt = '1;
    else             q_nxt = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/frame_stats_bank.sv
module frame_stats_bank
  import fstat_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 32,
  parameter int          OCT_W     = 40,
  parameter int          LEN_W     = 16,
  parameter int          MAX_LEN   = 9600,
  parameter logic [15:0] BANK_BASE = 16'h0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  input  logic [LEN_W-1:0]  fr_len,
  input  logic              fr_fcs_err,
  input  logic [1:0]        fr_cls,
  input  logic              fr_ctrl,
  input  logic              fr_pause,
  input  logic              fr_jabber,
  input  logic              fr_fragment,
  input  logic              clr_all,
  input  logic              rd_en,
  input  logic [15:0]       rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HI_W = OCT_W - DATA_W;

  logic                          rst_meta_n, rst_s_n;
  logic [NUM_CNT-1:0]            inc;
  logic [LEN_W-1:0]              pay_add, frm_add;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [OCT_W-1:0]              pay_q, frm_q;
  logic [DATA_W-1:0]             pay_hi_q, frm_hi_q, pay_hi_nxt, frm_hi_nxt;
  logic [DATA_W-1:0]             rd_nxt;
  logic                          hit;
  logic [7:0]                    off;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  fstat_classify #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) i_classify (
    .fr_valid, .fr_len, .fr_fcs_err, .fr_cls, .fr_ctrl, .fr_pause,
    .fr_jabber, .fr_fragment, .inc, .pay_add, .frm_add
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    fstat_acc #(.W(CNT_W), .IW(1)) i_cnt (
      .clk, .rst_n(rst_s_n), .clr(clr_all), .add(inc[g]), .q(cnt_q[g])
    );
  end

  fstat_acc #(.W(OCT_W), .IW(LEN_W)) i_pay (
    .clk, .rst_n(rst_s_n), .clr(clr_all), .add(pay_add), .q(pay_q)
  );
  fstat_acc #(.W(OCT_W), .IW(LEN_W)) i_frm (
    .clk, .rst_n(rst_s_n), .clr(clr_all), .add(frm_add), .q(frm_q)
  );

  assign hit = (rd_addr[15:8] == BANK_BASE[15:8]);
  assign off = rd_addr[7:0];

  always_comb begin
    rd_nxt     = '0;
    pay_hi_nxt = pay_hi_q;
    frm_hi_nxt = frm_hi_q;
    if (hit) begin
      for (int i = 0; i < NUM_CNT; i++)
        if (off == 8'(i)) rd_nxt = DATA_W'(cnt_q[i]);
      case (off)
        OFF_PAY_LO: begin
          rd_nxt     = pay_q[DATA_W-1:0];
          pay_hi_nxt = DATA_W'(pay_q[OCT_W-1:DATA_W]);
        end
        OFF_PAY_HI: rd_nxt = pay_hi_q;
        OFF_FRM_LO: begin
          rd_nxt     = frm_q[DATA_W-1:0];
          frm_hi_nxt = DATA_W'(frm_q[OCT_W-1:DATA_W]);
        end
        OFF_FRM_HI: rd_nxt = frm_hi_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rd_data  <= '0;
      pay_hi_q <= '0;
      frm_hi_q <= '0;
    end else if (rd_en) begin
      rd_data  <= rd_nxt;
      pay_hi_q <= pay_hi_nxt;
      frm_hi_q <= frm_hi_nxt;
    end
  end

  initial begin
    if (HI_W < 1 || HI_W > DATA_W) $error("OCT_W must lie in DATA_W+1..2*DATA_W");
    if (CNT_W > DATA_W)            $error("CNT_W must not exceed DATA_W");
  end
endmodule

// File: rtl/frame_stats_chk.sv
module frame_stats_chk
  import fstat_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 32,
  parameter int          OCT_W     = 40,
  parameter logic [15:0] BANK_BASE = 16'h0800
) (
  input logic                          clk,
  input logic                          rst_s_n,
  input logic                          fr_valid,
  input logic                          clr_all,
  input logic                          rd_en,
  input logic [15:0]                   rd_addr,
  input logic [DATA_W-1:0]             rd_data,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic [OCT_W-1:0]              pay_q,
  input logic [OCT_W-1:0]              frm_q
);
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr_all |=> (cnt_q == '0 && pay_q == '0 && frm_q == '0));

  a_r7_starts_no_wrap: assert property (@(posedge clk) disable iff (!rst_s_n)
    !clr_all |=> cnt_q[IX_STARTS] >= $past(cnt_q[IX_STARTS]));

  a_r7_pay_no_wrap: assert property (@(posedge clk) disable iff (!rst_s_n)
    !clr_all |=> pay_q >= $past(pay_q));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_en |=> $stable(rd_data));

  a_r9_other_bank: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_en && rd_addr[15:8] != BANK_BASE[15:8]) |=> rd_data == '0);

  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!fr_valid && !clr_all) |=> ($stable(cnt_q) && $stable(pay_q) && $stable(frm_q)));
endmodule

bind frame_stats_bank frame_stats_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .OCT_W(OCT_W), .BANK_BASE(BANK_BASE)
) i_chk (
  .clk(clk), .rst_s_n(rst_s_n), .fr_valid(fr_valid), .clr_all(clr_all),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .cnt_q(cnt_q), .pay_q(pay_q), .frm_q(frm_q)
);

// File: tb/test_frame_stats_bank.sv
module test_frame_stats_bank;
  localparam int          DW   = 16;
  localparam int          CW   = 8;
  localparam int          OW   = 32;
  localparam int          LW   = 16;
  localparam int          MAXL = 9600;
  localparam logic [15:0] BASE = 16'h0800;
  localparam int          NC   = 27;
  localparam int          CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fr_valid = 1'b0;
  logic [LW-1:0] fr_len = '0;
  logic          fr_fcs_err = 1'b0;
  logic [1:0]    fr_cls = 2'd0;
  logic          fr_ctrl = 1'b0;
  logic          fr_pause = 1'b0;
  logic          fr_jabber = 1'b0;
  logic          fr_fragment = 1'b0;
  logic          clr_all = 1'b0;
  logic          rd_en = 1'b0;
  logic [15:0]   rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int m [NC];
  longint m_pay = 0;
  longint m_frm = 0;

  always #4 clk = ~clk;

  frame_stats_bank #(
    .DATA_W(DW), .CNT_W(CW), .OCT_W(OW), .LEN_W(LW), .MAX_LEN(MAXL), .BANK_BASE(BASE)
  ) i_frame_stats_bank (
    .clk, .rst_n, .fr_valid, .fr_len, .fr_fcs_err, .fr_cls, .fr_ctrl,
    .fr_pause, .fr_jabber, .fr_fragment, .clr_all, .rd_en, .rd_addr, .rd_data
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bump(input int idx);
    if (m[idx] < CMAX) m[idx]++;
  endtask

  // expected effect of one frame, from the requirements
  task automatic model(input int len, input bit fcs, input int cls, input bit ctl,
                       input bit pau, input bit jab, input bit frg);
    bit err = fcs | jab | frg;
    bump(19);                                   // R5
    if (frg) bump(0);                           // R2
    if (jab) bump(1);
    if (fcs) bump(2);
    if (fcs && !frg && !jab && len >= 64 && len <= MAXL) bump(3);
    if (len == 64) bump(11);                    // R1
    else if (len >= 65 && len <= 127) bump(12);
    else if (len >= 128 && len <= 255) bump(13);
    else if (len >= 256 && len <= 511) bump(14);
    else if (len >= 512 && len <= 1023) bump(15);
    else if (len >= 1024 && len <= 1518) bump(16);
    else if (len >= 1519 && len <= MAXL) bump(17);
    else if (len > MAXL) bump(18);
    if (pau) bump(err ? 10 : 26);               // R3 R4
    else if (cls < 3) bump((err ? 4 : 20) + (ctl ? 3 : 0) + cls);
    if (!err) begin                             // R6
      m_frm += len;
      m_pay += (len >= 18) ? len - 18 : 0;
    end
  endtask

  task automatic send(input int len, input bit fcs = 0, input int cls = 0, input bit ctl = 0,
                      input bit pau = 0, input bit jab = 0, input bit frg = 0);
    @(negedge clk);
    fr_valid = 1'b1; fr_len = LW'(len); fr_fcs_err = fcs; fr_cls = 2'(cls);
    fr_ctrl = ctl; fr_pause = pau; fr_jabber = jab; fr_fragment = frg;
    @(negedge clk);
    fr_valid = 1'b0;
    model(len, fcs, cls, ctl, pau, jab, frg);
  endtask

  task automatic rd(input logic [15:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [DW-1:0] d;
    for (int i = 0; i < NC; i++) begin
      rd(BASE + 16'(i), d);
      chk($sformatf("%s counter %0d", tag, i), d, m[i]);
    end
    rd(BASE + 16'h20, d); chk({tag, " payload lo"}, d, m_pay & 16'hFFFF);
    rd(BASE + 16'h21, d); chk({tag, " payload hi"}, d, (m_pay >> 16) & 16'hFFFF);
    rd(BASE + 16'h22, d); chk({tag, " frame lo"}, d, m_frm & 16'hFFFF);
    rd(BASE + 16'h23, d); chk({tag, " frame hi"}, d, (m_frm >> 16) & 16'hFFFF);
  endtask

  task automatic t_reset;
    check_all("R9 reset state");
  endtask

  task automatic t_bins;
    int lens [16] = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519,
                      9600, 9601, 63, 700};
    for (int i = 0; i < 16; i++) send(lens[i]);
    check_all("R1 size bins");
  endtask

  task automatic t_errors;
    send(40, 1, 0, 0, 0, 0, 1);      // fragment with bad FCS: not sized
    send(9700, 1, 1, 0, 0, 1, 0);    // jabber with bad FCS
    send(100, 1, 2);                 // sized FCS error
    send(9600, 1, 0);                // sized at the maximum
    send(9601, 1, 0);                // FCS error above maximum
    check_all("R2 error causes");
  endtask

  task automatic t_err_class;
    for (int c = 0; c < 4; c++) begin
      send(200, 1, c, 0);
      send(80, 1, c, 1);
    end
    send(64, 0, 1, 1, 1, 1, 0);      // errored pause
    check_all("R3 errored classes");
  endtask

  task automatic t_ok_class;
    for (int c = 0; c < 4; c++) begin
      send(300, 0, c, 0);
      send(64, 0, c, 1);
    end
    send(64, 0, 1, 1, 1);            // good pause
    check_all("R4 good classes");
  endtask

  task automatic t_starts;
    logic [DW-1:0] d;
    send(64, 1, 0); send(1000); send(20, 0, 0, 0, 0, 0, 1);
    rd(BASE + 16'd19, d);
    chk("R5 frame starts", d, m[19]);
  endtask

  task automatic t_octets;
    send(1500, 0, 2); send(64, 0, 0, 1); send(10);  // 10 bytes: payload floors at 0
    send(500, 1);                                   // errored: no octets
    check_all("R6 octet totals");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      fr_len = LW'(64 + i * 300); fr_fcs_err = i[0]; fr_cls = 2'(i);
      fr_ctrl = i[1]; fr_jabber = i[2]; fr_fragment = i[0];
    end
    @(negedge clk);
    fr_fcs_err = 0; fr_jabber = 0; fr_fragment = 0;
    check_all("R11 no strobe");
  endtask

  task automatic t_readmap;
    logic [DW-1:0] d;
    rd(BASE + 16'd19, d); chk("R9 starts nonzero", d != 0, 1);
    rd(BASE + 16'h1B, d); chk("R9 unmapped offset", d, 0);
    rd(BASE + 16'd19, d);
    rd(16'h0913, d);      chk("R9 other bank", d, 0);
    rd(BASE + 16'd19, d);
    repeat (3) @(negedge clk);
    chk("R9 hold without read", rd_data, m[19]);
  endtask

  task automatic t_latch;
    logic [DW-1:0] d;
    longint hi_then;
    rd(BASE + 16'h20, d);
    chk("R10 payload lo", d, m_pay & 16'hFFFF);
    hi_then = (m_pay >> 16) & 16'hFFFF;
    for (int i = 0; i < 8; i++) send(9600);
    chk("R10 total crossed word", (m_pay >> 16) != hi_then, 1);
    rd(BASE + 16'h21, d);
    chk("R10 latched payload hi", d, hi_then);
    rd(BASE + 16'h22, d);
    hi_then = (m_frm >> 16) & 16'hFFFF;
    send(9600); send(9600);
    rd(BASE + 16'h23, d);
    chk("R10 latched frame hi", d, hi_then);
    check_all("R10 fresh pair");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 260; i++) send(64);
    check_all("R7 saturation");
  endtask

  task automatic t_clear;
    @(negedge clk);
    clr_all = 1'b1; fr_valid = 1'b1; fr_len = LW'(100); fr_cls = 2'd0;
    @(negedge clk);
    clr_all = 1'b0; fr_valid = 1'b0;
    for (int i = 0; i < NC; i++) m[i] = 0;
    m_pay = 0; m_frm = 0;
    check_all("R8 clear wins");
    send(128, 0, 2);
    check_all("R8 count after clear");
  endtask

  initial begin
    for (int i = 0; i < NC; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_bins;
    t_errors;
    t_err_class;
    t_ok_class;
    t_starts;
    t_octets;
    t_idle;
    t_readmap;
    t_latch;
    t_sat;
    t_clear;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule